// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A bank of general-purpose pins controlled through a small memory-mapped register bus. Software drives pin output levels and output enables through dedicated write-one-to-set and write-one-to-clear addresses, so that one pin can change without a read-modify-write. Each input passes through a two-flop synchroniser. It can also pass, pin by pin, through a debounce filter. That filter is paced by one prescaler shared across the whole bank.

The filtered inputs feed per-pin rising-edge and falling-edge detectors. A detected edge on an enabled pin sets a sticky pending bit. There are two pending registers, one for each edge direction. Software acknowledges a pending bit by writing a one to it. A single interrupt line is raised while any pending bit is set. Per-pin pull enable and pull direction bits are turned into separate pull-up and pull-down controls for the pad.

The bus write takes effect on the clock edge where `bus_we` is high. Read data is registered: `bus_rdata` shows the register at the address presented one clock earlier. No read strobe is needed.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero. `pin_out`, `pin_oe`, both pull outputs, `irq` and `bus_rdata` are all zero.
- R2: The output-value register is at 0x10. A write to 0x10 loads it. Ones written to 0x14 set the matching bits, and ones written to 0x18 clear them. Bits written as zero keep their value. `pin_out` follows the register one clock after the write.
- R3: The output-enable register is at 0x04. A write to 0x04 loads it. Ones written to 0x1C set bits and ones written to 0x20 clear bits, leaving every other bit alone. `pin_oe` follows one clock after the write.
- R4: `pin_in` bit n passes through two flops, then through the optional debounce. The result reads back at 0x00, bit n. `bus_rdata` returns, one clock later, the register at the address presented. Addresses that are not mapped, and the set/clear addresses, read as zero. A write to 0x00 has no effect.
- R5: Bit n of the rising-pending register at 0x30 becomes set when two conditions hold: the filtered input of pin n goes from 0 to 1, and bit n of the rising-enable register at 0x28 is one. With the enable bit at zero, a rising edge leaves the pending bit clear.
- R6: Bit n of the falling-pending register at 0x34 becomes set when the filtered input goes from 1 to 0 while bit n of the falling-enable register at 0x2C is one. If both enables are set, both edges are captured.
- R7: Writing ones to 0x30 or 0x34 clears exactly those pending bits. If a new edge on the same pin arrives in the same cycle as the clear, the pending bit stays set.
- R8: `irq` is high exactly when any bit of either pending register is set. It changes in the same cycle as the pending registers.
- R9: The debounce divider D sits in bits 29:16 of register 0x4C. The other bits of 0x4C read as zero. A prescaler ticks once every D+1 clocks. For a pin whose bit is set in the debounce-enable register at 0x24, the filtered value changes only on a tick, and only when the synchronised input at this tick and at the previous tick agree with each other and differ from the current filtered value.
- R10: The pull-enable register is at 0x50 and the pull-direction register at 0x54 (1 means up, 0 means down). `pad_pull_up` is enable AND direction. `pad_pull_dn` is enable AND NOT direction. With enable clear, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| pad_pull_up | output | 32 | Pull-up request per pin |
| pad_pull_dn | output | 32 | Pull-down request per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
Edge detection is tried with pins whose rising-only, falling-only and both-edge enables differ. This separates a detector that ignores its enable from one that mixes up the edge directions. A clear write is placed in the exact cycle a new edge arrives, which shows whether clear or set wins. A debounced pin first gets a one-cycle glitch and then a long stable level. This distinguishes a filter that passes noise from one that never settles. A long run of random pin toggles, writes to every address and reads is then compared clock by clock against a behavioural model. That run exposes stray bits from masking errors in the set and clear paths.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 8;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_IN        = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OE        = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT       = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_OE_SET    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_OE_CLR    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DB_EN     = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_EN   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_RISE_PEND = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_FALL_PEND = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_DIV       = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_PULL_EN   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PULL_DIR  = 8'h54;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W     = 32,
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [W-1:0]     db_en,
  input  logic [DIV_W-1:0] div,
  output logic [W-1:0]     dout
);
  logic [DIV_W-1:0] pre_cnt;
  logic             tick;
  logic [W-1:0]     held;     // filtered level per pin
  logic [W-1:0]     last_smp; // sample taken at previous tick
  logic [W-1:0]     flip;

  assign tick = (pre_cnt >= div);
  assign flip = tick ? (~(din ^ last_smp) & (din ^ held)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      held     <= '0;
      last_smp <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      held    <= held ^ flip;
      if (tick) last_smp <= din;
    end
  end

  for (genvar p = 0; p < W; p++) begin : g_sel
    assign dout[p] = db_en[p] ? held[p] : din[p];
  end

  // R9: a filtered level only moves on a prescaler tick
  a_r9_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (held != $past(held)) |-> $past(tick));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] rise_ack,
  input  logic [W-1:0] fall_ack,
  output logic [W-1:0] rise_pend,
  output logic [W-1:0] fall_pend,
  output logic         irq
);
  logic [W-1:0] level_q;
  logic [W-1:0] rise_hit, fall_hit;
  logic [W-1:0] rise_nx, fall_nx;

  assign rise_hit = level & ~level_q & rise_en;
  assign fall_hit = ~level & level_q & fall_en;
  // a fresh edge outranks an acknowledge in the same cycle
  assign rise_nx  = (rise_pend & ~rise_ack) | rise_hit;
  assign fall_nx  = (fall_pend & ~fall_ack) | fall_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= '0;
      rise_pend <= '0;
      fall_pend <= '0;
      irq       <= 1'b0;
    end else begin
      level_q   <= level;
      rise_pend <= rise_nx;
      fall_pend <= fall_nx;
      irq       <= |(rise_nx | fall_nx);
    end
  end

  a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ((rise_pend & ~$past(rise_pend) & ~$past(rise_en)) == '0));
  a_r6_fall_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ((fall_pend & ~$past(fall_pend) & ~$past(fall_en)) == '0));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ((rise_pend & $past(rise_ack) & ~$past(rise_hit)) == '0));
  a_r8_irq_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq == |(rise_pend | fall_pend));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 14,
  parameter int DIV_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pad_pull_up,
  output logic [NPINS-1:0]  pad_pull_dn,
  output logic              irq
);
  typedef logic [NPINS-1:0] pins_t;

  pins_t wmask;
  pins_t out_q, oe_q, dben_q, ren_q, fen_q, pen_q, pdir_q;
  pins_t out_n, oe_n, dben_n, ren_n, fen_n, pen_n, pdir_n;
  pins_t rise_ack, fall_ack, rise_pend, fall_pend;
  pins_t synced, filtered;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [DATA_W-1:0] rd_v;

  assign wmask = bus_wdata[NPINS-1:0];

  always_comb begin
    out_n = out_q;  oe_n = oe_q;   dben_n = dben_q;
    ren_n = ren_q;  fen_n = fen_q; pen_n = pen_q;
    pdir_n = pdir_q; div_n = div_q;
    rise_ack = '0;  fall_ack = '0;
    if (bus_we) begin
      case (bus_addr)
        OFS_OUT:       out_n  = wmask;
        OFS_OUT_SET:   out_n  = out_q | wmask;
        OFS_OUT_CLR:   out_n  = out_q & ~wmask;
        OFS_OE:        oe_n   = wmask;
        OFS_OE_SET:    oe_n   = oe_q | wmask;
        OFS_OE_CLR:    oe_n   = oe_q & ~wmask;
        OFS_DB_EN:     dben_n = wmask;
        OFS_RISE_EN:   ren_n  = wmask;
        OFS_FALL_EN:   fen_n  = wmask;
        OFS_RISE_PEND: rise_ack = wmask;
        OFS_FALL_PEND: fall_ack = wmask;
        OFS_DIV:       div_n  = bus_wdata[DIV_LSB +: DIV_W];
        OFS_PULL_EN:   pen_n  = wmask;
        OFS_PULL_DIR:  pdir_n = wmask;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_v = '0;
    case (bus_addr)
      OFS_IN:        rd_v[NPINS-1:0] = filtered;
      OFS_OE:        rd_v[NPINS-1:0] = oe_q;
      OFS_OUT:       rd_v[NPINS-1:0] = out_q;
      OFS_DB_EN:     rd_v[NPINS-1:0] = dben_q;
      OFS_RISE_EN:   rd_v[NPINS-1:0] = ren_q;
      OFS_FALL_EN:   rd_v[NPINS-1:0] = fen_q;
      OFS_RISE_PEND: rd_v[NPINS-1:0] = rise_pend;
      OFS_FALL_PEND: rd_v[NPINS-1:0] = fall_pend;
      OFS_DIV:       rd_v[DIV_LSB +: DIV_W] = div_q;
      OFS_PULL_EN:   rd_v[NPINS-1:0] = pen_q;
      OFS_PULL_DIR:  rd_v[NPINS-1:0] = pdir_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0; oe_q <= '0; dben_q <= '0; ren_q <= '0; fen_q <= '0;
      pen_q <= '0; pdir_q <= '0; div_q <= '0; bus_rdata <= '0;
      pad_pull_up <= '0; pad_pull_dn <= '0;
    end else begin
      out_q <= out_n; oe_q <= oe_n; dben_q <= dben_n; ren_q <= ren_n;
      fen_q <= fen_n; pen_q <= pen_n; pdir_q <= pdir_n; div_q <= div_n;
      bus_rdata   <= rd_v;
      pad_pull_up <= pen_n & pdir_n;
      pad_pull_dn <= pen_n & ~pdir_n;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(synced));

  gpio_debounce #(.W(NPINS), .DIV_W(DIV_W)) u_deb (
    .clk(clk), .rst(rst), .din(synced), .db_en(dben_q), .div(div_q),
    .dout(filtered));

  gpio_edge_irq #(.W(NPINS)) u_edge (
    .clk(clk), .rst(rst), .level(filtered), .rise_en(ren_q), .fall_en(fen_q),
    .rise_ack(rise_ack), .fall_ack(fall_ack), .rise_pend(rise_pend),
    .fall_pend(fall_pend), .irq(irq));

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_OUT_SET) |=> ((pin_out & $past(wmask)) == $past(wmask)));
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_OE_CLR) |=> ((pin_oe & $past(wmask)) == '0));
  a_r10_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((pad_pull_up & pad_pull_dn) == '0));
endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out, pin_oe, pad_pull_up, pad_pull_dn;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  logic chk_on = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_bank uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .irq(irq));

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_s1, m_s2, m_held, m_smp, m_lvl_q;
  logic [31:0] m_out, m_oe, m_dben, m_ren, m_fen, m_rp, m_fp, m_pen, m_pdir;
  logic [31:0] m_div, m_rdata;
  logic [7:0]  m_raddr;
  logic        m_irq;
  int          m_cnt;
  logic [31:0] t_filt, t_rise, t_fall, t_flip;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_held = 0; m_smp = 0; m_lvl_q = 0;
      m_out = 0; m_oe = 0; m_dben = 0; m_ren = 0; m_fen = 0;
      m_rp = 0; m_fp = 0; m_pen = 0; m_pdir = 0; m_div = 0;
      m_rdata = 0; m_irq = 0; m_cnt = 0; m_raddr = bus_addr;
    end else begin
      t_filt = (m_held & m_dben) | (m_s2 & ~m_dben);
      m_raddr = bus_addr;
      case (bus_addr)
        8'h00: m_rdata = t_filt;
        8'h04: m_rdata = m_oe;
        8'h10: m_rdata = m_out;
        8'h24: m_rdata = m_dben;
        8'h28: m_rdata = m_ren;
        8'h2C: m_rdata = m_fen;
        8'h30: m_rdata = m_rp;
        8'h34: m_rdata = m_fp;
        8'h4C: m_rdata = m_div << 16;
        8'h50: m_rdata = m_pen;
        8'h54: m_rdata = m_pdir;
        default: m_rdata = 0;
      endcase
      t_rise = t_filt & ~m_lvl_q & m_ren;
      t_fall = ~t_filt & m_lvl_q & m_fen;
      if (m_cnt >= int'(m_div)) begin
        t_flip = ~(m_s2 ^ m_smp) & (m_s2 ^ m_held);
        m_held = m_held ^ t_flip;
        m_smp  = m_s2;
        m_cnt  = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (bus_we) begin
        case (bus_addr)
          8'h10: m_out = bus_wdata;
          8'h14: m_out = m_out | bus_wdata;
          8'h18: m_out = m_out & ~bus_wdata;
          8'h04: m_oe = bus_wdata;
          8'h1C: m_oe = m_oe | bus_wdata;
          8'h20: m_oe = m_oe & ~bus_wdata;
          8'h24: m_dben = bus_wdata;
          8'h28: m_ren = bus_wdata;
          8'h2C: m_fen = bus_wdata;
          8'h30: m_rp = m_rp & ~bus_wdata;
          8'h34: m_fp = m_fp & ~bus_wdata;
          8'h4C: m_div = (bus_wdata >> 16) & 32'h3FFF;
          8'h50: m_pen = bus_wdata;
          8'h54: m_pdir = bus_wdata;
          default: ;
        endcase
      end
      m_rp = m_rp | t_rise;
      m_fp = m_fp | t_fall;
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_lvl_q = t_filt;
      m_irq = |(m_rp | m_fp);
    end
  end

  task automatic cmp(input logic [31:0] got, input logic [31:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h04: return "R3 oe read";
      8'h10: return "R2 out read";
      8'h24, 8'h4C: return "R9 debounce read";
      8'h28, 8'h30: return "R5 rise read";
      8'h2C, 8'h34: return "R6 fall read";
      8'h50, 8'h54: return "R10 pull read";
      default: return "R4 input/unmapped read";
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      cmp(pin_out, m_out, "R2 pin_out");
      cmp(pin_oe, m_oe, "R3 pin_oe");
      cmp(pad_pull_up, m_pen & m_pdir, "R10 pull_up");
      cmp(pad_pull_dn, m_pen & ~m_pdir, "R10 pull_dn");
      cmp({31'b0, irq}, {31'b0, m_irq}, "R8 irq");
      cmp(bus_rdata, m_rdata, tag_of(m_raddr));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    cmp(bus_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] alist [16] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                             8'h28, 8'h2C, 8'h30, 8'h34, 8'h4C, 8'h50, 8'h54, 8'h08};

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp(pin_out, 0, "R1 pin_out");
    cmp(pin_oe, 0, "R1 pin_oe");
    cmp(pad_pull_up | pad_pull_dn, 0, "R1 pulls");
    cmp({31'b0, irq}, 0, "R1 irq");
    cmp(bus_rdata, 0, "R1 rdata");
    rst = 1'b0;
    chk_on = 1'b1;

    // R2: output value load/set/clear
    wr(8'h10, 32'hF0F0_0000);
    wr(8'h14, 32'h0000_00FF);
    wr(8'h18, 32'h0030_0000);
    cmp(pin_out, 32'hF0C0_00FF, "R2 set/clear mask");
    rd_chk(8'h10, 32'hF0C0_00FF, "R2 readback");
    rd_chk(8'h14, 32'h0, "R4 set address reads zero");

    // R3: output enable set/clear
    wr(8'h1C, 32'h0000_FFFF);
    wr(8'h20, 32'h0000_0F00);
    cmp(pin_oe, 32'h0000_F0FF, "R3 oe set/clear");
    rd_chk(8'h04, 32'h0000_F0FF, "R3 readback");

    // R10: pulls
    wr(8'h50, 32'h0000_000F);
    wr(8'h54, 32'h0000_0105);
    cmp(pad_pull_up, 32'h0000_0005, "R10 pull up");
    cmp(pad_pull_dn, 32'h0000_000A, "R10 pull down");

    // R4: synchronised input, write to 0x00 ignored
    pin_in = 32'hA5A5_0000;
    idle(2);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'hA5A5_0000, "R4 input value");
    rd_chk(8'h08, 32'h0, "R4 unmapped");

    // R5/R6: edges with distinct enables
    pin_in = 0;
    idle(4);
    wr(8'h28, 32'h0000_000F);
    wr(8'h2C, 32'h0000_000C);
    pin_in = 32'h0000_00FF;
    idle(3);
    rd_chk(8'h30, 32'h0000_000F, "R5 rising pending");
    rd_chk(8'h34, 32'h0, "R6 no falling yet");
    cmp({31'b0, irq}, 1, "R8 irq raised");
    pin_in = 0;
    idle(3);
    rd_chk(8'h34, 32'h0000_000C, "R6 falling pending both-edge pins");
    rd_chk(8'h30, 32'h0000_000F, "R5 rising stays sticky");

    // R7: acknowledge by ones
    wr(8'h30, 32'h0000_0005);
    rd_chk(8'h30, 32'h0000_000A, "R7 partial clear");
    wr(8'h30, 32'h0000_000A);
    wr(8'h34, 32'h0000_000C);
    cmp({31'b0, irq}, 0, "R8 irq drops");
    rd_chk(8'h30, 32'h0, "R7 all cleared");

    // R7: clear colliding with a fresh edge on pin 1
    pin_in = 32'h0000_0002;
    idle(2);
    wr(8'h30, 32'h0000_0002);
    rd_chk(8'h30, 32'h0000_0002, "R7 edge beats clear");
    wr(8'h30, 32'h0000_0002);
    pin_in = 0;
    idle(4);

    // R9: debounce divider and filter
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'h3FFF_0000, "R9 divider field only");
    wr(8'h4C, 32'h0003_0000);
    wr(8'h24, 32'h0010_0000);
    wr(8'h28, 32'h0010_000F);
    idle(10);
    pin_in = 32'h0010_0000;
    idle(1);
    pin_in = 0;
    idle(12);
    rd_chk(8'h00, 32'h0, "R9 glitch rejected");
    rd_chk(8'h30, 32'h0, "R9 no edge from glitch");
    pin_in = 32'h0010_0000;
    idle(16);
    rd_chk(8'h00, 32'h0010_0000, "R9 stable level passes");
    rd_chk(8'h30, 32'h0010_0000, "R9 debounced edge pending");

    // random phase, compared against the model every clock
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) pin_in = pin_in ^ (32'h1 << ($urandom % 32));
      bus_addr  = alist[$urandom % 16];
      bus_we    = ($urandom % 3 == 0);
      bus_wdata = $urandom;
      if (bus_addr == 8'h4C) bus_wdata = bus_wdata & 32'h0007_0000;
      @(negedge clk);
    end
    bus_we = 1'b0;
    idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule